// File: doc/BRIEF.md
# Programmable Chip-Select Qualifier Unit

This unit drives one active-low chip-select line for an external memory or peripheral. A host writes a 16-bit option word. An outside comparator supplies an address match for each bus cycle. On a match, the unit checks the cycle direction and, for 16-bit ports, the byte lanes. It then asserts the select together with either the address strobe or the data strobe.

The unit also has a synchronous mode. In that mode it does not assert the select at once. It raises a pending request toward the bus interface and waits for that request to be accepted. It then drives the select for one high phase of the external peripheral clock (ECLK).

A boot build of the unit leaves reset already enabled, so the boot memory can be fetched before any software runs. A general build leaves reset disabled. The host can write new options at any time. A new word takes effect only once no bus cycle is in progress.

Top module: `csq_unit`

## Requirements
- R1: After reset, the boot build (BOOT_SELECT=1) asserts the select on a matched read or write with the address strobe, on either byte, in asynchronous mode. The general build (BOOT_SELECT=0) resets to all zeros and never asserts.
- R2: Option bit 15 picks the timing. At 0 the select follows the bus strobes. At 1 the select never follows the strobes directly; a qualified cycle goes through the synchronous handshake instead.
- R3: With port16 high, bits 14:13 qualify the byte lanes: 00 never asserts, 01 needs lowerLane, 10 needs upperLane, 11 needs either lane.
- R4: With port16 low, bits 14:13 and both lane inputs have no effect on the select.
- R5: Bits 12:11 qualify direction, where busRead=1 marks a read: 00 never asserts, 01 asserts on reads only, 10 on writes only, 11 on both.
- R6: In asynchronous mode, bit 10 picks the strobe: 0 uses addrStrobe and 1 uses dataStrobe. The select is low only while that strobe is high.
- R7: In asynchronous mode, csN returns high in the same cycle that the chosen strobe or addrMatch falls, with no register delay.
- R8: In synchronous mode, a qualified cycle, sampled on a clock edge while addrStrobe is high, raises eclkPending one clock later. eclkPending stays high, with csN high, until pendAck is sampled high.
- R9: After pendAck, csN goes low one clock after the first sampled rising ECLK transition. It goes high again one clock after the next sampled falling ECLK transition.
- R10: A write (cfgWe) updates the option word that is in use only while no bus cycle is active, that is while addrStrobe is low and the handshake is idle. A write made during a cycle takes effect after that cycle ends.
- R11: Without addrMatch, no option setting asserts the select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Option word write enable |
| cfgData | input | CFG_W | Option word write data |
| addrMatch | input | 1 | Address match from the external comparator |
| busRead | input | 1 | 1 = read cycle, 0 = write cycle |
| lowerLane | input | 1 | Lower byte lane active |
| upperLane | input | 1 | Upper byte lane active |
| port16 | input | 1 | Target port is 16 bits wide |
| addrStrobe | input | 1 | Address strobe, active high |
| dataStrobe | input | 1 | Data strobe, active high |
| eclk | input | 1 | External peripheral clock, sampled by clk |
| pendAck | input | 1 | Bus interface accepts the pending request |
| csN | output | 1 | Chip select, active low |
| eclkPending | output | 1 | Synchronous cycle request to the bus interface |

## Verification
A wrong decode of the option word shows at once at csN, in the same cycle that the strobe is driven. The vector table therefore covers every byte, direction and strobe code against lane and direction patterns that must either assert or must not. A stuck handshake state shows within one clock as eclkPending that is missing or never clears, or as csN held low past the ECLK fall. An option word loaded early shows as csN dropping in the middle of a cycle that should have kept its select.

// File: rtl/csq_pkg.sv
package csq_pkg;

  localparam int OPT_W      = 16;
  localparam int MODE_POS   = 15;
  localparam int LANE_HI    = 14;
  localparam int LANE_LO    = 13;
  localparam int DIR_HI     = 12;
  localparam int DIR_LO     = 11;
  localparam int STROBE_POS = 10;

  // asynchronous, both lanes, read and write, address strobe
  localparam logic [OPT_W-1:0] BOOT_OPT = 16'h7800;

  typedef enum logic [2:0] {
    SYNC_IDLE,
    SYNC_PEND,
    SYNC_WAITRISE,
    SYNC_ASSERT,
    SYNC_DONE
  } syncState_t;

  typedef struct packed {
    logic loadLive;
  } ctlStrobe_t;

  typedef struct packed {
    logic syncMode;
    logic useDataStrobe;
    logic dirOk;
    logic laneOk;
  } cfgDecode_t;

endpackage

// File: rtl/csq_datapath.sv
module csq_datapath
  import csq_pkg::*;
#(
  parameter int CFG_W       = 16,
  parameter bit BOOT_SELECT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgData,
  input  ctlStrobe_t       ctl,
  input  logic             busRead,
  input  logic             lowerLane,
  input  logic             upperLane,
  input  logic             port16,
  output cfgDecode_t       dec
);

  localparam logic [CFG_W-1:0] RESET_OPT = BOOT_SELECT ? CFG_W'(BOOT_OPT) : '0;

  logic [CFG_W-1:0] shadowCfg;
  logic [CFG_W-1:0] liveCfg;
  logic [1:0]       laneSel;
  logic [1:0]       dirSel;
  logic             laneHit;
  logic             dirHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowCfg <= RESET_OPT;
    end else if (cfgWe) begin
      shadowCfg <= cfgData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      liveCfg <= RESET_OPT;
    end else if (ctl.loadLive) begin
      liveCfg <= shadowCfg;
    end
  end

  assign laneSel = liveCfg[LANE_HI:LANE_LO];
  assign dirSel  = liveCfg[DIR_HI:DIR_LO];

  always_comb begin
    unique case (laneSel)
      2'b01:   laneHit = lowerLane;
      2'b10:   laneHit = upperLane;
      2'b11:   laneHit = lowerLane | upperLane;
      default: laneHit = 1'b0;
    endcase
  end

  always_comb begin
    unique case (dirSel)
      2'b01:   dirHit = busRead;
      2'b10:   dirHit = ~busRead;
      2'b11:   dirHit = 1'b1;
      default: dirHit = 1'b0;
    endcase
  end

  always_comb begin
    dec.syncMode      = liveCfg[MODE_POS];
    dec.useDataStrobe = liveCfg[STROBE_POS];
    dec.dirOk         = dirHit;
    dec.laneOk        = port16 ? laneHit : 1'b1;
  end

endmodule

// File: rtl/csq_control.sv
module csq_control
  import csq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  cfgDecode_t dec,
  input  logic       addrMatch,
  input  logic       addrStrobe,
  input  logic       dataStrobe,
  input  logic       eclk,
  input  logic       pendAck,
  output ctlStrobe_t ctl,
  output logic       csN,
  output logic       eclkPending
);

  syncState_t syncState;
  syncState_t syncNext;
  logic       eclkPrev;
  logic       eclkRise;
  logic       eclkFall;
  logic       qualified;
  logic       chosenStrobe;
  logic       asyncAssert;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eclkPrev <= 1'b0;
    end else begin
      eclkPrev <= eclk;
    end
  end

  assign eclkRise     = eclk & ~eclkPrev;
  assign eclkFall     = ~eclk & eclkPrev;
  assign qualified    = addrMatch & dec.dirOk & dec.laneOk;
  assign chosenStrobe = dec.useDataStrobe ? dataStrobe : addrStrobe;
  assign asyncAssert  = ~dec.syncMode & qualified & chosenStrobe;

  always_comb begin
    syncNext = syncState;
    unique case (syncState)
      SYNC_IDLE:     if (dec.syncMode && qualified && addrStrobe) syncNext = SYNC_PEND;
      SYNC_PEND:     if (pendAck) syncNext = SYNC_WAITRISE;
      SYNC_WAITRISE: if (eclkRise) syncNext = SYNC_ASSERT;
      SYNC_ASSERT:   if (eclkFall) syncNext = SYNC_DONE;
      SYNC_DONE:     if (!addrStrobe) syncNext = SYNC_IDLE;
      default:       syncNext = SYNC_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncState <= SYNC_IDLE;
    end else begin
      syncState <= syncNext;
    end
  end

  assign csN          = ~(asyncAssert | (syncState == SYNC_ASSERT));
  assign eclkPending  = (syncState == SYNC_PEND);
  assign ctl.loadLive = ~addrStrobe & (syncState == SYNC_IDLE);

  // R11
  match_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !dec.syncMode) |-> addrMatch);

  // R8
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eclkPending && !pendAck) |=> eclkPending);

  // R8
  pend_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    eclkPending |-> csN);

  // R9
  sync_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(csN) && dec.syncMode) |-> ($past(eclk) && !$past(eclk, 2)));

endmodule

// File: rtl/csq_unit.sv
module csq_unit
  import csq_pkg::*;
#(
  parameter int CFG_W       = 16,
  parameter bit BOOT_SELECT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             addrMatch,
  input  logic             busRead,
  input  logic             lowerLane,
  input  logic             upperLane,
  input  logic             port16,
  input  logic             addrStrobe,
  input  logic             dataStrobe,
  input  logic             eclk,
  input  logic             pendAck,
  output logic             csN,
  output logic             eclkPending
);

  ctlStrobe_t ctl;
  cfgDecode_t dec;

  csq_datapath #(
    .CFG_W       (CFG_W),
    .BOOT_SELECT (BOOT_SELECT)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgData   (cfgData),
    .ctl       (ctl),
    .busRead   (busRead),
    .lowerLane (lowerLane),
    .upperLane (upperLane),
    .port16    (port16),
    .dec       (dec)
  );

  csq_control u_control (
    .clk         (clk),
    .rstN        (rstN),
    .dec         (dec),
    .addrMatch   (addrMatch),
    .addrStrobe  (addrStrobe),
    .dataStrobe  (dataStrobe),
    .eclk        (eclk),
    .pendAck     (pendAck),
    .ctl         (ctl),
    .csN         (csN),
    .eclkPending (eclkPending)
  );

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrStrobe && $past(addrStrobe) && $stable(busRead) && $stable(lowerLane)
     && $stable(upperLane) && $stable(port16)) |-> $stable(dec));

endmodule

// File: tb/csq_unit_tb.sv
module csq_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [15:0] cfgData = '0;
  logic        addrMatch = 1'b0;
  logic        busRead = 1'b0;
  logic        lowerLane = 1'b0;
  logic        upperLane = 1'b0;
  logic        port16 = 1'b0;
  logic        addrStrobe = 1'b0;
  logic        dataStrobe = 1'b0;
  logic        eclk = 1'b0;
  logic        pendAck = 1'b0;
  logic        csN;
  logic        eclkPending;
  logic        genCsN;
  logic        genPending;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  csq_unit u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .addrMatch(addrMatch), .busRead(busRead), .lowerLane(lowerLane),
    .upperLane(upperLane), .port16(port16), .addrStrobe(addrStrobe),
    .dataStrobe(dataStrobe), .eclk(eclk), .pendAck(pendAck),
    .csN(csN), .eclkPending(eclkPending)
  );

  csq_unit #(.BOOT_SELECT(1'b0)) u_gen (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .addrMatch(addrMatch), .busRead(busRead), .lowerLane(lowerLane),
    .upperLane(upperLane), .port16(port16), .addrStrobe(addrStrobe),
    .dataStrobe(dataStrobe), .eclk(eclk), .pendAck(pendAck),
    .csN(genCsN), .eclkPending(genPending)
  );

  // {option word, port16, read, lower, upper, match, addrStrobe, dataStrobe, expected csN}
  localparam int NVEC = 17;
  localparam logic [23:0] VECS [NVEC] = '{
    {16'h7800, 8'b1_1_1_0_1_1_0_0},  // R5 read, both
    {16'h7800, 8'b1_0_0_1_1_1_0_0},  // R5 write, both
    {16'h7800, 8'b1_1_1_0_0_1_0_1},  // R11 no match
    {16'h7800, 8'b1_1_1_0_1_0_1_1},  // R6 wrong strobe
    {16'h2800, 8'b1_1_1_0_1_1_0_0},  // R3 lower hit
    {16'h2800, 8'b1_1_0_1_1_1_0_1},  // R3 lower miss
    {16'h4800, 8'b1_1_0_1_1_1_0_0},  // R3 upper hit
    {16'h4800, 8'b1_1_1_0_1_1_0_1},  // R3 upper miss
    {16'h1800, 8'b1_1_1_1_1_1_0_1},  // R3 lanes disabled
    {16'h1800, 8'b0_1_0_0_1_1_0_0},  // R4 8-bit ignores disable
    {16'h2800, 8'b0_1_0_1_1_1_0_0},  // R4 8-bit ignores lanes
    {16'h7000, 8'b1_1_1_1_1_1_0_1},  // R5 write-only on read
    {16'h7000, 8'b1_0_1_1_1_1_0_0},  // R5 write-only on write
    {16'h6000, 8'b1_1_1_1_1_1_0_1},  // R5 reserved read
    {16'h6000, 8'b1_0_1_1_1_1_0_1},  // R5 reserved write
    {16'h7C00, 8'b1_1_1_0_1_1_0_1},  // R6 data strobe absent
    {16'h7C00, 8'b1_1_1_0_1_1_1_0}   // R6 data strobe present
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [15:0] val);
    @(negedge clk);
    cfgWe = 1'b1;
    cfgData = val;
    @(negedge clk);
    cfgWe = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic busIdle();
    @(negedge clk);
    addrStrobe = 1'b0;
    dataStrobe = 1'b0;
    addrMatch = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check("R1 idle boot", csN, 1'b1);
    check("R1 idle general", genCsN, 1'b1);
    busRead = 1'b1; lowerLane = 1'b1; port16 = 1'b1;
    addrMatch = 1'b1; addrStrobe = 1'b1;
    #1;
    check("R1 boot select live", csN, 1'b0);
    check("R1 general select off", genCsN, 1'b1);
    busIdle();

    for (int i = 0; i < NVEC; i++) begin
      writeCfg(VECS[i][23:8]);
      @(negedge clk);
      port16 = VECS[i][7]; busRead = VECS[i][6];
      lowerLane = VECS[i][5]; upperLane = VECS[i][4];
      addrMatch = VECS[i][3]; addrStrobe = VECS[i][2];
      dataStrobe = VECS[i][1];
      #1;
      check($sformatf("R3/R4/R5/R6/R11 vector %0d", i), csN, VECS[i][0]);
      busIdle();
    end

    // R7: release follows the strobe with no delay
    writeCfg(16'h7800);
    @(negedge clk);
    port16 = 1'b1; busRead = 1'b1; lowerLane = 1'b1;
    addrMatch = 1'b1; addrStrobe = 1'b1;
    #1 check("R7 asserted", csN, 1'b0);
    @(posedge clk); #1;
    addrStrobe = 1'b0;
    #0.5 check("R7 same-cycle release", csN, 1'b1);
    busIdle();

    // R10: a write during a cycle is held off
    @(negedge clk);
    addrMatch = 1'b1; addrStrobe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b1; cfgData = 16'h0000;
    @(negedge clk);
    cfgWe = 1'b0;
    repeat (3) @(negedge clk);
    #1 check("R10 held during cycle", csN, 1'b0);
    busIdle();
    @(negedge clk);
    @(negedge clk);
    addrMatch = 1'b1; addrStrobe = 1'b1;
    #1 check("R10 applied after cycle", csN, 1'b1);
    busIdle();

    // R2, R8, R9: synchronous handshake
    writeCfg(16'hF800);
    @(negedge clk);
    eclk = 1'b0;
    addrMatch = 1'b1; addrStrobe = 1'b1; dataStrobe = 1'b1;
    #1 check("R2 no strobe-timed select", csN, 1'b1);
    @(negedge clk); #1;
    check("R8 pending raised", eclkPending, 1'b1);
    repeat (3) @(negedge clk);
    #1 check("R8 pending held", eclkPending, 1'b1);
    check("R8 select quiet while pending", csN, 1'b1);
    pendAck = 1'b1;
    @(negedge clk);
    pendAck = 1'b0;
    #1 check("R8 pending cleared", eclkPending, 1'b0);
    repeat (2) @(negedge clk);
    #1 check("R9 waits for rise", csN, 1'b1);
    eclk = 1'b1;
    @(negedge clk); #1;
    check("R9 asserted after rise", csN, 1'b0);
    repeat (3) @(negedge clk);
    #1 check("R9 held over high phase", csN, 1'b0);
    eclk = 1'b0;
    #1 check("R9 not yet released", csN, 1'b0);
    @(negedge clk); #1;
    check("R9 released after fall", csN, 1'b1);
    busIdle();
    @(negedge clk); #1;
    check("R8 idle after cycle", eclkPending, 1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule